// File: doc/BRIEF.md
# Nyquist-filter decimator with two-channel demultiplexing

This block is the digital back end of a multiplexed delta-sigma converter that keeps no memory between samples. Each cycle it can take one signed 4-bit quantizer code at the oversampled rate. The code runs through a symmetric raised-cosine FIR whose impulse response crosses zero at every nonzero multiple of the oversampling ratio from its centre. One filtered value in every `OVR` accepted codes is kept. The kept value sits at the phase that lines up with the filter centre, so the contributions of neighbouring interleaved samples cancel there. Kept values go to the two channel outputs in turn.

Nothing is cleared between samples. The only isolation between channels comes from the zero crossings of the impulse response. For the default `OVR` = 4 the table has 15 taps, scaled by 64. Distance 0 from the centre is 64. Distances 1 to 7 are 57, 38, 17, 0, -8, -8 and -4.

The input is a valid/ready stream. Both channel outputs share one output register stage and one `out_ready` input. The upstream side is stalled only while a kept value waits in that stage and `out_ready` is low. Each channel has its own valid strobe.

Top module: `nyq_decim_demux`

## Requirements
- R1: After a synchronous reset, both `ch_valid` bits are 0 and `in_ready` is 1.
- R2: `in_ready` is 1 exactly when no channel strobe is high or `out_ready` is 1. A code offered while `in_ready` is 0 is not taken and changes no output.
- R3: One kept value is produced for every 4 accepted codes: on the 4th, 8th, 12th and later accepted codes after reset. The value appears on the output the cycle after that code is accepted.
- R4: The kept value after accepted code n equals the sum over j = 0..14 of h(j-7)·x[n-j]. Here h is the table above, x is the code read as 4-bit two's complement, and codes before reset count as 0. The result never exceeds the 14-bit signed output.
- R5: If nonzero codes occur only at accepted indices that are multiples of 4 (counting from 0), each kept value is exactly 64 times the code at its centre, with no crosstalk from its neighbours.
- R6: Kept values go alternately to channel 0 (`ch_valid[0]`, `ch_data[13:0]`) and channel 1 (`ch_valid[1]`, `ch_data[27:14]`), starting with channel 0 after reset. At most one strobe is high at a time.
- R7: While a strobe is high and `out_ready` is 0, that strobe stays high and its data holds.
- R8: The filter history is never cleared between kept values. Only reset clears it, so codes taken before a reset contribute nothing afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input code offered |
| in_ready | output | 1 | Input code taken when both are high |
| in_code | input | 4 | Signed quantizer code |
| out_ready | input | 1 | Downstream takes the pending channel value |
| ch_valid | output | 2 | Per-channel strobe, bit i for channel i |
| ch_data | output | 28 | Channel values, 14 bits each, channel 0 in the low half |

## Verification
The embedded properties watch the mutual exclusion and alternation of the two strobes and the holding of data under back-pressure. They also check that a new strobe always follows an accepted code, that a refused code leaves the outputs untouched, and that the accumulated sum stays inside the output range. The cancellation of crosstalk is shown only by the bench scenarios, which feed zero-stuffed streams and compare against a convolution computed from the coefficient table. The same applies to exact filter values under random codes and back-pressure, full-scale saturation margins and clearing of history by reset.

// File: rtl/nyq_pkg.sv
`timescale 1ns/1ps
package nyq_pkg;
  // Raised-cosine (roll-off one half) taps at distance d from the centre,
  // scaled by 64; zero at distance 4 so every 4th output is free of crosstalk.
  function automatic int nyq_coef(input int d);
    int a;
    a = (d < 0) ? -d : d;
    case (a)
      0: return 64;
      1: return 57;
      2: return 38;
      3: return 17;
      5: return -8;
      6: return -8;
      7: return -4;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/nyq_tapline.sv
`timescale 1ns/1ps
module nyq_tapline #(
  parameter int W    = 4,
  parameter int TAPS = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift,
  input  logic [W-1:0]      din,
  output logic [TAPS*W-1:0] window
);
  localparam int DEPTH = TAPS - 1;

  logic [W-1:0] q [DEPTH];

  assign window[W-1:0] = din;

  for (genvar k = 0; k < DEPTH; k++) begin : g_tap
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst)        q[k] <= '0;
        else if (shift) q[k] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst)        q[k] <= '0;
        else if (shift) q[k] <= q[k-1];
      end
    end
    assign window[(k+1)*W +: W] = q[k];
  end

  // R8: the newest stored tap holds the code shifted in one cycle earlier
  assert_tap_shift_R8: assert property (@(posedge clk) disable iff (rst)
    shift |=> q[0] == $past(din));
endmodule

// File: rtl/nyq_fir_sym.sv
`timescale 1ns/1ps
module nyq_fir_sym #(
  parameter int W     = 4,
  parameter int HALF  = 7,
  parameter int OUT_W = 14
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [(2*HALF+1)*W-1:0]   window,
  output logic [OUT_W-1:0]          y
);
  import nyq_pkg::*;

  localparam int MAXV = (2 ** (OUT_W - 1)) - 1;
  localparam int MINV = -(2 ** (OUT_W - 1));

  int acc;

  // Symmetric taps: pre-add the two samples at equal distance, one multiply each.
  always_comb begin
    acc = 0;
    for (int d = 0; d <= HALF; d++) begin
      if (d == 0) begin
        acc = acc + nyq_coef(0) * int'($signed(window[HALF*W +: W]));
      end else begin
        acc = acc + nyq_coef(d) *
              (int'($signed(window[(HALF-d)*W +: W])) +
               int'($signed(window[(HALF+d)*W +: W])));
      end
    end
  end

  assign y = OUT_W'(acc);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (acc <= MAXV) && (acc >= MINV));
endmodule

// File: rtl/nyq_decim_out.sv
`timescale 1ns/1ps
module nyq_decim_out #(
  parameter int OVR        = 4,
  parameter int KEEP_PHASE = 3,
  parameter int NCH        = 2,
  parameter int OUT_W      = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accept,
  input  logic [OUT_W-1:0]     y,
  input  logic                 out_ready,
  output logic [NCH-1:0]       ch_valid,
  output logic [NCH*OUT_W-1:0] ch_data
);
  localparam int PW = (OVR > 1) ? $clog2(OVR) : 1;
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [PW-1:0]    phase;
  logic [CW-1:0]    ptr;
  logic             kept;
  logic             vq [NCH];
  logic [OUT_W-1:0] dq [NCH];

  assign kept = accept && (phase == PW'(KEEP_PHASE));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      ptr   <= '0;
    end else begin
      if (accept) phase <= (phase == PW'(OVR - 1)) ? '0 : phase + 1'b1;
      if (kept)   ptr   <= (ptr == CW'(NCH - 1)) ? '0 : ptr + 1'b1;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        vq[i] <= 1'b0;
        dq[i] <= '0;
      end else if (kept && ptr == CW'(i)) begin
        vq[i] <= 1'b1;
        dq[i] <= y;
      end else if (out_ready) begin
        vq[i] <= 1'b0;
      end
    end
    assign ch_valid[i]                = vq[i];
    assign ch_data[i*OUT_W +: OUT_W]  = dq[i];

    // R7: a pending value is held until the consumer takes it
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (ch_valid[i] && !out_ready) |=> ch_valid[i] && $stable(ch_data[i*OUT_W +: OUT_W]));

    // R3: a fresh strobe always follows an accepted input code
    assert_kept_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(ch_valid[i]) |-> $past(accept));
  end

  // R6: alternation check with an independent record of the last loaded channel
  logic          seen_q;
  logic [CW-1:0] last_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if ($rose(ch_valid[0])) begin
      seen_q <= 1'b1;
      last_q <= '0;
    end else if ($rose(ch_valid[NCH-1])) begin
      seen_q <= 1'b1;
      last_q <= CW'(NCH - 1);
    end
  end

  assert_onehot_strobes_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_valid));

  assert_alternate_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(ch_valid[0]) && seen_q) |-> last_q != '0);
endmodule

// File: rtl/nyq_decim_demux.sv
`timescale 1ns/1ps
module nyq_decim_demux #(
  parameter int IN_W       = 4,
  parameter int OVR        = 4,
  parameter int HALF_SPAN  = 7,
  parameter int OUT_W      = 14,
  parameter int NCH        = 2,
  parameter int KEEP_PHASE = HALF_SPAN % OVR
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [IN_W-1:0]      in_code,
  input  logic                 out_ready,
  output logic [NCH-1:0]       ch_valid,
  output logic [NCH*OUT_W-1:0] ch_data
);
  localparam int TAPS = 2 * HALF_SPAN + 1;

  logic                 accept;
  logic [TAPS*IN_W-1:0] window;
  logic [OUT_W-1:0]     y;

  initial begin
    assert (OVR == 4 && HALF_SPAN <= 7)
      else $error("coefficient table is laid out for OVR 4 and span 7");
  end

  assign in_ready = !(|ch_valid) || out_ready;
  assign accept   = in_valid && in_ready;

  nyq_tapline #(.W(IN_W), .TAPS(TAPS)) u_taps (
    .clk    (clk),
    .rst    (rst),
    .shift  (accept),
    .din    (in_code),
    .window (window)
  );

  nyq_fir_sym #(.W(IN_W), .HALF(HALF_SPAN), .OUT_W(OUT_W)) u_fir (
    .clk    (clk),
    .rst    (rst),
    .window (window),
    .y      (y)
  );

  nyq_decim_out #(.OVR(OVR), .KEEP_PHASE(KEEP_PHASE), .NCH(NCH), .OUT_W(OUT_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .y         (y),
    .out_ready (out_ready),
    .ch_valid  (ch_valid),
    .ch_data   (ch_data)
  );

  // R2: an offer refused by back-pressure leaves the channel strobes unchanged
  assert_refused_no_effect_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> $stable(ch_valid) && $stable(ch_data));
endmodule

// File: tb/nyq_decim_demux_bench.sv
`timescale 1ns/1ps
module nyq_decim_demux_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_code = '0;
  logic        out_ready = 1'b1;
  logic [1:0]  ch_valid;
  logic [27:0] ch_data;

  always #2.5 clk = ~clk;

  nyq_decim_demux u_nyq_decim_demux (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .out_ready(out_ready), .ch_valid(ch_valid), .ch_data(ch_data)
  );

  int checks = 0;
  int errors = 0;
  int hist [0:4095];
  int nacc = 0;
  int nkept = 0;
  int nseen = 0;
  int exp_val[$];
  int exp_ch[$];
  int isi_val[$];
  bit isi_mode = 0;
  bit hold_prev = 0;
  int hold_ch = 0;
  logic [27:0] hold_data = '0;
  int cyc = 0;
  bit done = 0;

  function automatic int h(input int d);
    int a;
    a = (d < 0) ? -d : d;
    case (a)
      0: return 64; 1: return 57; 2: return 38; 3: return 17;
      5: return -8; 6: return -8; 7: return -4;
      default: return 0;
    endcase
  endfunction

  function automatic int xat(input int k);
    return (k < 0) ? 0 : hist[k];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clear_model();
    nacc = 0; nkept = 0; nseen = 0;
    exp_val.delete(); exp_ch.delete(); isi_val.delete();
    hold_prev = 0;
  endtask

  // One cycle: drive at the falling edge, observe after settling.
  task automatic cycle(input bit v, input logic [3:0] c, input bit rdy);
    int ch;
    int act;
    int e;
    int s;
    @(negedge clk);
    in_valid = v; in_code = c; out_ready = rdy;
    #1;
    // R2: stall rule
    check(in_ready == (!(|ch_valid) || rdy), "R2 in_ready", int'(in_ready), int'(!(|ch_valid) || rdy));
    // R6: at most one strobe
    if (ch_valid == 2'b11) check(0, "R6 both strobes", int'(ch_valid), 1);
    // R7: held value
    if (hold_prev) begin
      check(ch_valid[hold_ch] == 1'b1, "R7 strobe held", int'(ch_valid[hold_ch]), 1);
      check(ch_data == hold_data, "R7 data held", int'(ch_data), int'(hold_data));
    end
    if (|ch_valid) begin
      ch = ch_valid[1] ? 1 : 0;
      act = int'($signed(ch_data[ch*14 +: 14]));
      if (rdy) begin
        if (exp_val.size() == 0) begin
          check(0, "R3 unexpected output", act, 0);
        end else begin
          e = exp_val.pop_front();
          s = isi_val.pop_front();
          check(act == e, "R4 filtered value", act, e);
          check(ch == exp_ch.pop_front(), "R6 channel order", ch, nseen % 2);
          if (isi_mode) check(act == s, "R5 zero crosstalk", act, s);
          nseen++;
        end
        hold_prev = 0;
      end else begin
        hold_prev = 1; hold_ch = ch; hold_data = ch_data;
      end
    end else begin
      hold_prev = 0;
    end
    if (v && in_ready) begin
      int acc;
      hist[nacc] = int'($signed(c));
      nacc++;
      if (nacc % 4 == 0) begin
        acc = 0;
        for (int j = 0; j < 15; j++) acc += h(j - 7) * xat(nacc - 1 - j);
        exp_val.push_back(acc);
        exp_ch.push_back(nkept % 2);
        isi_val.push_back(64 * xat(nacc - 8));
        nkept++;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    clear_model();
    #1;
    check(ch_valid == 2'b00, "R1 strobes after reset", int'(ch_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) cycle(1'b0, 4'd0, 1'b1);
    check(exp_val.size() == 0, "R3 pending outputs", exp_val.size(), 0);
    check(nseen == nacc / 4, "R3 output count", nseen, nacc / 4);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lfsr;
    bit v;
    bit r;
    do_reset();

    // R5: zero-stuffed stream, codes swept over the full 4-bit range
    isi_mode = 1;
    for (int i = 0; i < 160; i++) begin
      logic [3:0] c;
      c = (i % 4 == 0) ? 4'((i / 4) % 16) : 4'd0;
      cycle(1'b1, c, 1'b1);
    end
    drain();
    isi_mode = 0;

    // R2, R4, R7: pseudo-random codes, gaps and back-pressure
    lfsr = 32'h1ACE5;
    for (int i = 0; i < 1200; i++) begin
      lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
      v = ((lfsr >> 20) % 4) != 0;
      r = ((lfsr >> 23) % 3) != 0;
      cycle(v, 4'(lfsr >> 8), r);
    end
    drain();

    // R4: full-scale negative then positive runs (output range margin)
    for (int i = 0; i < 64; i++) cycle(1'b1, 4'b1000, 1'b1);
    for (int i = 0; i < 64; i++) cycle(1'b1, 4'b0111, 1'b1);
    for (int i = 0; i < 32; i++) cycle(1'b1, (i % 2 == 0) ? 4'b0111 : 4'b1000, 1'b1);
    drain();

    // R8: history survives between kept values but not across reset
    for (int i = 0; i < 21; i++) cycle(1'b1, 4'b0111, 1'b1);
    do_reset();
    for (int i = 0; i < 32; i++) begin
      cycle(1'b1, 4'd0, 1'b1);
      if (|ch_valid) check(ch_data == '0, "R8 history cleared", int'(ch_data), 0);
    end
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule